// File: doc/BRIEF.md
# Digitally Trimmed Real-Time-Clock Prescaler

This block turns a nominal 32.768 kHz oscillator clock into a one-cycle pulse per second for downstream time counters. It divides in two stages, first to a 512 Hz intermediate rate and then to 1 Hz. A slow or fast crystal is corrected digitally. Once per correction window (64 seconds by default), the block either adds extra counts to the first divider stage or drops counts from it. The number of counts is set by a signed trim code.

Two small registers sit behind a plain write/read port. A control register holds the calibration-mode flag. A trim register holds a sign and a 5-bit magnitude, and it accepts writes only while calibration mode is on. In calibration mode a shared output pin carries an uncorrected 512 Hz square wave, so the raw oscillator error can be measured with a frequency counter. Outside calibration mode the same pin passes the external power-fail input through. An oscillator-enable input freezes the whole prescaler.

Top module: `rtc_trim_prescaler`

## Requirements
- R1: With no correction pending, consecutive `tick_1hz` pulses are exactly 2^(STG1_W+STG2_W) clock cycles apart, and each pulse is one cycle wide.
- R2: Address 0 is the control register. Bit 0 is the calibration-mode flag and all other read bits are 0.
- R3: While calibration mode is 1, `cal_pfo_out` is a square wave with a period of 2^STG1_W cycles and a 50% duty cycle. It is derived before correction, so trim bursts do not disturb it.
- R4: While calibration mode is 0, `cal_pfo_out` equals `pfail_in`.
- R5: A write to the trim register while calibration mode is 0 is ignored, and the stored value reads back unchanged.
- R6: Address 1 is the trim register. Bits 4:0 hold the magnitude N and bit 5 holds the sign. Both registers read back their current contents in either mode.
- R7: With sign 1, the tick interval that begins at each window-boundary tick is shortened by N*STEP cycles, because counts are added.
- R8: With sign 0, that interval is lengthened by N*STEP cycles, because counts are removed.
- R9: A window spans 2^WIN_W ticks. The trim value is sampled only at a window boundary, so a write in the middle of a window takes effect at the next boundary. N = 0 applies no correction.
- R10: While `osc_en` is 0, the prescaler and the square wave hold their state and no tick is produced. The interval that contains the freeze grows by the number of frozen cycles.
- R11: Reset is asserted asynchronously and released synchronously. After reset, both registers read 0 and `tick_1hz` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_osc | input | 1 | Oscillator clock, nominally 32.768 kHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en | input | 1 | Oscillator enable; 0 freezes the prescaler |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 trim |
| reg_wdata | input | 6 | Register write data |
| reg_rdata | output | 6 | Read data for the register at `reg_addr` |
| pfail_in | input | 1 | Power-fail signal shown on the shared pin outside calibration mode |
| cal_pfo_out | output | 1 | Shared pin: the 512 Hz square wave or the power-fail signal |
| tick_1hz | output | 1 | One-cycle pulse per second |

## Verification
The hardest situation to reach from the ports is a correction burst: it occurs only in the few cycles after a window-boundary tick, and it must be tied to the trim value that was stored before that boundary. The bench builds a reduced prescaler through the parameters, with a 4-count first stage, an 8-count second stage and 4-tick windows. It counts ticks itself and writes trim values at chosen tick indices, some before a boundary and one just after it. It then predicts which interval the boundary alters and by how much. The oscillator-enable freeze is placed inside an interval whose expected length already accounts for the frozen cycles.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;

  // Width of the trim magnitude field
  localparam int MAG_W  = 5;
  // Register data width: magnitude plus sign
  localparam int DATA_W = MAG_W + 1;

  typedef enum logic {
    ADDR_CTRL = 1'b0,
    ADDR_TRIM = 1'b1
  } reg_addr_e;

  typedef struct packed {
    logic             sign;  // 1: add counts, 0: remove counts
    logic [MAG_W-1:0] mag;
  } trim_t;

endpackage

// File: rtl/osc_trim_rst_sync.sv
module osc_trim_rst_sync (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_n_sync = stage_q[1];

endmodule

// File: rtl/osc_trim_regs.sv
module osc_trim_regs
  import osc_trim_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              cal_mode,
  output trim_t             trim
);

  logic  cal_q, cal_d;
  trim_t trim_q, trim_d;
  logic  wr_ctrl, wr_trim;

  assign wr_ctrl = wr && (reg_addr_e'(addr) == ADDR_CTRL);
  // Trim updates are only accepted in calibration mode
  assign wr_trim = wr && (reg_addr_e'(addr) == ADDR_TRIM) && cal_q;

  always_comb begin
    cal_d  = cal_q;
    trim_d = trim_q;
    if (wr_ctrl) begin
      cal_d = wdata[0];
    end
    if (wr_trim) begin
      trim_d = trim_t'(wdata);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_q  <= 1'b0;
      trim_q <= '0;
    end else begin
      cal_q  <= cal_d;
      trim_q <= trim_d;
    end
  end

  always_comb begin
    if (reg_addr_e'(addr) == ADDR_CTRL) begin
      rdata = {{(DATA_W-1){1'b0}}, cal_q};
    end else begin
      rdata = trim_q;
    end
  end

  assign cal_mode = cal_q;
  assign trim     = trim_q;

  AST_TRIM_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !cal_q |=> $stable(trim_q)); // R5

endmodule

// File: rtl/osc_trim_divider.sv
module osc_trim_divider
  import osc_trim_pkg::*;
#(
  parameter int STG1_W = 6,  // 32768 Hz -> 512 Hz
  parameter int STG2_W = 9,  // 512 Hz -> 1 Hz
  parameter int WIN_W  = 6,  // ticks per correction window (log2)
  parameter int STEP   = 4   // counts per magnitude step
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             trim_sign,
  input  logic [MAG_W-1:0] trim_mag,
  output logic             tick,
  output logic             sq_raw
);

  localparam int PEND_MAX = ((1 << MAG_W) - 1) * STEP;
  localparam int PEND_W   = $clog2(PEND_MAX + 1);

  logic [STG1_W-1:0] cnt1_q, cnt1_d;
  logic [STG2_W-1:0] cnt2_q, cnt2_d;
  logic [WIN_W-1:0]  win_q, win_d;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic              sign_q, sign_d;
  logic [STG1_W-1:0] raw_q, raw_d;
  logic              tick_q, tick_d;

  logic [1:0]        inc;
  logic [STG1_W:0]   sum1;
  logic [STG2_W:0]   sum2;
  logic              c1, c2, win_wrap;

  // Counts added to stage 1 this cycle: 0 (frozen or swallowed), 1, 2 (injected)
  always_comb begin
    if (!en) begin
      inc = 2'd0;
    end else if (pend_q != '0) begin
      inc = sign_q ? 2'd2 : 2'd0;
    end else begin
      inc = 2'd1;
    end
  end

  always_comb begin
    sum1     = {1'b0, cnt1_q} + (STG1_W+1)'(inc);
    c1       = sum1[STG1_W];
    cnt1_d   = sum1[STG1_W-1:0];
    sum2     = {1'b0, cnt2_q} + (STG2_W+1)'(c1);
    c2       = sum2[STG2_W];
    cnt2_d   = sum2[STG2_W-1:0];
    win_wrap = c2 && (win_q == {WIN_W{1'b1}});
    win_d    = win_q + WIN_W'(c2);
    tick_d   = c2;
    raw_d    = en ? raw_q + STG1_W'(1) : raw_q;
    pend_d   = pend_q;
    sign_d   = sign_q;
    if (win_wrap) begin
      pend_d = PEND_W'(trim_mag) * PEND_W'(STEP);
      sign_d = trim_sign;
    end else if (en && (pend_q != '0)) begin
      pend_d = pend_q - PEND_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt1_q <= '0;
      cnt2_q <= '0;
      win_q  <= '0;
      pend_q <= '0;
      sign_q <= 1'b0;
      raw_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      cnt1_q <= cnt1_d;
      cnt2_q <= cnt2_d;
      win_q  <= win_d;
      pend_q <= pend_d;
      sign_q <= sign_d;
      raw_q  <= raw_d;
      tick_q <= tick_d;
    end
  end

  assign tick   = tick_q;
  assign sq_raw = raw_q[STG1_W-1];

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q |=> !tick_q); // R1
  AST_FROZEN_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !tick_q); // R10
  AST_SQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(raw_q)); // R10
  AST_PEND_LOAD_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q > $past(pend_q)) |-> $past(win_wrap)); // R9

endmodule

// File: rtl/rtc_trim_prescaler.sv
module rtc_trim_prescaler
  import osc_trim_pkg::*;
#(
  parameter int STG1_W = 6,
  parameter int STG2_W = 9,
  parameter int WIN_W  = 6,
  parameter int STEP   = 4
) (
  input  logic              clk_osc,
  input  logic              rst_n,
  input  logic              osc_en,
  input  logic              reg_wr,
  input  logic              reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              pfail_in,
  output logic              cal_pfo_out,
  output logic              tick_1hz
);

  logic  rst_n_sync;
  logic  cal_mode;
  trim_t trim;
  logic  sq_raw;

  osc_trim_rst_sync i_rst_sync (
    .clk         (clk_osc),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_sync)
  );

  osc_trim_regs i_regs (
    .clk      (clk_osc),
    .rst_n    (rst_n_sync),
    .wr       (reg_wr),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .rdata    (reg_rdata),
    .cal_mode (cal_mode),
    .trim     (trim)
  );

  osc_trim_divider #(
    .STG1_W (STG1_W),
    .STG2_W (STG2_W),
    .WIN_W  (WIN_W),
    .STEP   (STEP)
  ) i_divider (
    .clk       (clk_osc),
    .rst_n     (rst_n_sync),
    .en        (osc_en),
    .trim_sign (trim.sign),
    .trim_mag  (trim.mag),
    .tick      (tick_1hz),
    .sq_raw    (sq_raw)
  );

  assign cal_pfo_out = cal_mode ? sq_raw : pfail_in;

endmodule

// File: tb/test_rtc_trim_prescaler.sv
module test_rtc_trim_prescaler;

  logic       clk_osc = 1'b0;
  logic       rst_n;
  logic       osc_en;
  logic       reg_wr;
  logic       reg_addr;
  logic [5:0] reg_wdata;
  logic [5:0] reg_rdata;
  logic       pfail_in;
  logic       cal_pfo_out;
  logic       tick_1hz;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int last_tick_cyc = 0;
  int tick_idx = 0;
  bit done = 0;

  typedef struct {
    int idx;
    int len;
    string req;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk_osc = ~clk_osc;

  rtc_trim_prescaler #(
    .STG1_W (2),
    .STG2_W (3),
    .WIN_W  (2),
    .STEP   (1)
  ) i_rtc_trim_prescaler (
    .clk_osc     (clk_osc),
    .rst_n       (rst_n),
    .osc_en      (osc_en),
    .reg_wr      (reg_wr),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .pfail_in    (pfail_in),
    .cal_pfo_out (cal_pfo_out),
    .tick_1hz    (tick_1hz)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp_v, $time);
    end
  endtask

  // Driver side of the scoreboard: expected interval ending at tick idx
  task automatic push_exp(input int idx, input int len, input string req);
    exp_t e;
    e.idx = idx;
    e.len = len;
    e.req = req;
    sb_q.push_back(e);
  endtask

  task automatic reg_write(input bit a, input logic [5:0] d);
    @(negedge clk_osc);
    reg_wr    = 1'b1;
    reg_addr  = a;
    reg_wdata = d;
    @(negedge clk_osc);
    reg_wr    = 1'b0;
  endtask

  task automatic reg_check(input bit a, input logic [5:0] exp_v, input string req);
    reg_addr = a;
    #1;
    check(reg_rdata == exp_v, req, int'(reg_rdata), int'(exp_v));
  endtask

  task automatic wait_tick(input int k);
    wait (tick_idx >= k);
  endtask

  // Monitor: measure tick intervals, pop and compare expectations
  always @(negedge clk_osc) begin
    cyc++;
    if (tick_1hz) begin
      tick_idx++;
      while (sb_q.size() > 0 && sb_q[0].idx < tick_idx) begin
        check(1'b0, {sb_q[0].req, " missed"}, tick_idx, sb_q[0].idx);
        void'(sb_q.pop_front());
      end
      if (sb_q.size() > 0 && sb_q[0].idx == tick_idx) begin
        check(cyc - last_tick_cyc == sb_q[0].len, sb_q[0].req,
              cyc - last_tick_cyc, sb_q[0].len);
        void'(sb_q.pop_front());
      end
      last_tick_cyc = cyc;
    end
  end

  initial begin
    repeat (20000) @(posedge clk_osc);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", tick_idx, 31);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic s [0:7];
    logic p0;
    rst_n     = 1'b0;
    osc_en    = 1'b1;
    reg_wr    = 1'b0;
    reg_addr  = 1'b0;
    reg_wdata = '0;
    pfail_in  = 1'b0;
    repeat (3) @(negedge clk_osc);
    // R11: reset state
    check(tick_1hz == 1'b0, "R11 tick in reset", int'(tick_1hz), 0);
    reg_check(1'b0, 6'h00, "R11 ctrl reset");
    reg_check(1'b1, 6'h00, "R11 trim reset");
    @(negedge clk_osc);
    rst_n = 1'b1;
    repeat (3) @(negedge clk_osc);
    // R4: pin follows power-fail outside calibration mode
    pfail_in = 1'b1; #1;
    check(cal_pfo_out == 1'b1, "R4 pfail high", int'(cal_pfo_out), 1);
    pfail_in = 1'b0; #1;
    check(cal_pfo_out == 1'b0, "R4 pfail low", int'(cal_pfo_out), 0);
    // R5: trim write outside calibration mode is ignored
    reg_write(1'b1, 6'h25);
    reg_check(1'b1, 6'h00, "R5 trim locked");
    // R1/R9: uncorrected intervals
    push_exp(2, 32, "R1 base interval");
    push_exp(3, 32, "R1 base interval");
    push_exp(5, 32, "R9 zero trim at boundary");

    wait_tick(5);
    reg_write(1'b0, 6'h3F);
    reg_check(1'b0, 6'h01, "R2 ctrl readback");
    reg_write(1'b1, 6'h25);
    reg_check(1'b1, 6'h25, "R6 trim readback");
    push_exp(6, 32, "R1 base interval");
    push_exp(8, 32, "R1 before boundary");
    push_exp(9, 27, "R7 add five counts");
    push_exp(10, 32, "R7 after burst");

    // R3: square wave during the correction burst after tick 8
    wait_tick(8);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_osc);
      s[i] = cal_pfo_out;
    end
    for (int i = 0; i < 4; i++) begin
      check(s[i] == s[i+4], "R3 period", int'(s[i+4]), int'(s[i]));
    end
    for (int i = 0; i < 2; i++) begin
      check(s[i] != s[i+2], "R3 half period toggle", int'(s[i+2]), int'(!s[i]));
    end

    wait_tick(10);
    reg_write(1'b1, 6'h03);
    push_exp(12, 32, "R1 base interval");
    push_exp(13, 35, "R8 remove three counts");
    push_exp(14, 32, "R8 after burst");

    wait_tick(14);
    reg_write(1'b1, 6'h2A);
    push_exp(17, 22, "R7 add ten counts");
    push_exp(18, 32, "R7 after burst");

    wait_tick(21);
    reg_write(1'b1, 6'h27);
    push_exp(22, 32, "R9 mid-window write waits");
    push_exp(25, 25, "R9 applied at next boundary");

    wait_tick(25);
    reg_write(1'b0, 6'h00);
    reg_check(1'b0, 6'h00, "R2 ctrl cleared");
    reg_write(1'b1, 6'h00);
    reg_check(1'b1, 6'h27, "R5 trim kept when locked");
    pfail_in = 1'b1; #1;
    check(cal_pfo_out == 1'b1, "R4 pin back to pfail", int'(cal_pfo_out), 1);
    pfail_in = 1'b0;
    push_exp(29, 25, "R6 stored trim still applied");

    wait_tick(29);
    reg_write(1'b0, 6'h01);
    push_exp(30, 39, "R10 freeze extends interval");
    @(negedge clk_osc);
    osc_en = 1'b0;
    p0 = cal_pfo_out;
    for (int i = 0; i < 7; i++) begin
      @(negedge clk_osc);
      check(cal_pfo_out == p0, "R10 square wave held", int'(cal_pfo_out), int'(p0));
      check(tick_1hz == 1'b0, "R10 no tick frozen", int'(tick_1hz), 0);
    end
    osc_en = 1'b1;

    wait_tick(31);
    check(sb_q.size() == 0, "R1 all intervals seen", sb_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule